// File: doc/BRIEF.md
# Egress Buffer Fill-Count Interrupter

This block is a 32-bit-word egress FIFO. An internal producer fills it and an external consumer empties it. Besides storing words, it counts how many words have been accepted since the last interrupt point. When that count reaches a fixed block size (`THRESH` words), it raises a sticky interrupt so that the consumer can fetch a whole block at once. For asynchronous traffic, a word tagged as the last of a packet raises the interrupt early, so a short packet tail is not stranded in the buffer. When a block or packet event fires, the pending count restarts from zero. Every new block, or every new packet end, can therefore fire the interrupt again.

On the producer side, `src_valid` qualifies `src_data` and `src_eop`, and `src_ready` reports that space is free (`fill_level` below `DEPTH`). The ready signal does not stall the producer. A beat presented with `src_valid` high while `src_ready` is low is discarded rather than held, and it latches the `overflow` flag. The producer is expected to watch `src_ready` before driving a beat. On the consumer side, `usr_avail` reports that at least one word is stored. A one-cycle `usr_rd_en` pops the oldest word into the `usr_rd_data` register. A read strobe while the buffer is empty pops nothing, leaves `usr_rd_data` at its last value, and latches `underflow`. The control and status pins are plain levels.

Top module: `egress_fill_notifier`

## Requirements
- R1: After reset, `fill_level` and `fill_pending` are 0, `usr_avail`, `irq`, `overflow` and `underflow` are 0, and `src_ready` is 1.
- R2: Words leave in the order they were accepted. `usr_rd_data` shows the popped word from the clock edge that samples `usr_rd_en` onward.
- R3: The interrupt condition is met when the accepted word brings the count since the last interrupt point to `THRESH`. One clock edge later, `irq` is 1 and `fill_pending` is 0.
- R4: After one threshold interrupt, another `THRESH` accepted words fire the interrupt condition again, with no need to empty the buffer.
- R5: An accepted word with `src_eop` = 1 sets `irq` and zeroes `fill_pending` on the next edge, whatever the count was.
- R6: `irq` stays 1 until an edge samples `irq_clr` = 1. That edge drops it to 0 if no new event occurs in the same cycle.
- R7: A threshold or end-of-packet event in the same cycle as `irq_clr` leaves `irq` at 1.
- R8: When `fill_level` equals `DEPTH`, `src_ready` is 0. A beat offered then is dropped: it is not stored, not counted, and its end-of-packet tag has no effect. The beat also sets `overflow`, which stays 1 until reset. A write and a read in the same full cycle complete only the read.
- R9: A read strobe while `fill_level` is 0 leaves `usr_rd_data` unchanged and sets `underflow`, which stays 1 until reset.
- R10: `fill_level` rises by one per accepted write and falls by one per accepted read, and is unchanged when both occur. `usr_avail` is 1 exactly when `fill_level` is nonzero.
- R11: Reads do not change `fill_pending` or raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Producer beat present |
| src_ready | output | 1 | Space available; beats offered while low are dropped |
| src_data | input | DW | Producer word |
| src_eop | input | 1 | Beat is the last word of a packet |
| usr_rd_en | input | 1 | Consumer pop strobe |
| usr_avail | output | 1 | At least one word stored |
| usr_rd_data | output | DW | Last popped word (registered) |
| irq | output | 1 | Sticky fill interrupt |
| irq_clr | input | 1 | One-cycle interrupt clear |
| fill_level | output | $clog2(DEPTH)+1 | Words currently stored |
| fill_pending | output | $clog2(THRESH+1) | Words accepted since the last interrupt point |
| overflow | output | 1 | Sticky: a beat was dropped while full |
| underflow | output | 1 | Sticky: a read was attempted while empty |

## Verification
Every registered result is due at the first rising edge that samples the stimulus. This covers the level, the pending count, the interrupt, both flags and the popped word. `src_ready` and `usr_avail` follow the level directly. The bench drives inputs just after a falling edge and compares outputs at the next falling edge, so each comparison lands exactly one edge after its stimulus. The stimulus table pairs each cycle's inputs with the interrupt, pending count and level due after that edge. Directed sequences then confirm word order, full and empty behaviour, and the dropped beat's lack of effect.

// File: rtl/efn_pkg.sv
package efn_pkg;
  // Per-cycle transfer decision shared by the storage and interrupt logic.
  typedef struct packed {
    logic wr_ok;   // producer beat accepted this cycle
    logic rd_ok;   // consumer pop accepted this cycle
    logic eop;     // accepted beat closes a packet
  } efn_xfer_t;
endpackage

// File: rtl/efn_ctrl.sv
module efn_ctrl
  import efn_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          wr_eop,
  input  logic          rd_req,
  output efn_xfer_t     xfer,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          has_room,
  output logic          has_data,
  output logic          ovf,
  output logic          udf
);
  assign has_room = (level != LW'(DEPTH));
  assign has_data = (level != '0);

  always_comb begin
    xfer.wr_ok = wr_req && has_room;
    xfer.rd_ok = rd_req && has_data;
    xfer.eop   = wr_req && has_room && wr_eop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (xfer.wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (xfer.rd_ok) rd_ptr <= rd_ptr + 1'b1;
      level <= level + LW'(xfer.wr_ok) - LW'(xfer.rd_ok);
      if (wr_req && !has_room) ovf <= 1'b1;
      if (rd_req && !has_data) udf <= 1'b1;
    end
  end

  // R10: occupancy never exceeds the storage depth
  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  // R10: a lone accepted write raises the level by one
  a_r10_level_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && has_room && !rd_req) |=> level == $past(level) + 1'b1);
  // R8: a full buffer with no read stays full and keeps the overflow flag
  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!has_room && !rd_req) |=> !has_room);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R9: read of an empty buffer is flagged
  a_r9_udf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !has_data) |=> udf);
endmodule

// File: rtl/efn_store.sv
module efn_store
  import efn_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  efn_xfer_t     xfer,
  input  logic [AW-1:0] wr_ptr,
  input  logic [AW-1:0] rd_ptr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (xfer.wr_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_data <= '0;
    else if (xfer.rd_ok) rd_data <= mem[rd_ptr];
  end

  // R9: without an accepted pop the output word holds
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer.rd_ok |=> $stable(rd_data));
endmodule

// File: rtl/efn_fill_irq.sv
module efn_fill_irq
  import efn_pkg::*;
#(
  parameter int THRESH = 8,
  localparam int PW = $clog2(THRESH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  efn_xfer_t     xfer,
  input  logic          clr,
  output logic [PW-1:0] pend,
  output logic          irq
);
  logic hit;

  assign hit = xfer.wr_ok && (xfer.eop || (pend == PW'(THRESH - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      if (hit)             pend <= '0;
      else if (xfer.wr_ok) pend <= pend + 1'b1;
      if (hit)      irq <= 1'b1;
      else if (clr) irq <= 1'b0;
    end
  end

  // R3: the pending count always stays below the block size
  a_r3_pend_below: assert property (@(posedge clk) disable iff (!rst_n)
    pend < PW'(THRESH));
  // R5: an accepted end-of-packet beat always raises the interrupt
  a_r5_eop_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer.wr_ok && xfer.eop) |=> (irq && pend == '0));
  // R6: sticky until cleared, and the clear works when nothing fires
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && clr && !xfer.wr_ok) |=> !irq);
  // R7: an event beside a clear keeps the interrupt set
  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && xfer.wr_ok && xfer.eop) |=> irq);
  // R11: cycles without an accepted write leave the count alone
  a_r11_no_read_effect: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer.wr_ok |=> $stable(pend));
endmodule

// File: rtl/egress_fill_notifier.sv
module egress_fill_notifier
  import efn_pkg::*;
#(
  parameter int DW     = 32,
  parameter int DEPTH  = 64,   // power of two, at least 2
  parameter int THRESH = 8,    // 1 .. DEPTH
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int PW = $clog2(THRESH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_valid,
  output logic          src_ready,
  input  logic [DW-1:0] src_data,
  input  logic          src_eop,
  input  logic          usr_rd_en,
  output logic          usr_avail,
  output logic [DW-1:0] usr_rd_data,
  output logic          irq,
  input  logic          irq_clr,
  output logic [LW-1:0] fill_level,
  output logic [PW-1:0] fill_pending,
  output logic          overflow,
  output logic          underflow
);
  if (THRESH < 1 || THRESH > DEPTH || (1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_cfg
    $error("egress_fill_notifier: unsupported DEPTH/THRESH");
  end

  efn_xfer_t     xfer;
  logic [AW-1:0] wr_ptr, rd_ptr;

  efn_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_req(src_valid), .wr_eop(src_eop), .rd_req(usr_rd_en),
    .xfer(xfer), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .level(fill_level), .has_room(src_ready), .has_data(usr_avail),
    .ovf(overflow), .udf(underflow)
  );

  efn_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .xfer(xfer),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .wr_data(src_data), .rd_data(usr_rd_data)
  );

  efn_fill_irq #(.THRESH(THRESH)) u_irq (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .clr(irq_clr),
    .pend(fill_pending), .irq(irq)
  );

  // R1: no interrupt can be pending while nothing has ever been written
  a_r1_quiet_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0 && !overflow && !irq && !src_valid) |=> !irq);
endmodule

// File: tb/egress_fill_notifier_test.sv
`timescale 1ns/1ps
module egress_fill_notifier_test;
  localparam int DW = 32, DEPTH = 64, THRESH = 8;
  localparam logic [31:0] BASE = 32'hC0DE_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic src_valid = 0, src_eop = 0, usr_rd_en = 0, irq_clr = 0;
  logic [DW-1:0] src_data = '0;
  logic src_ready, usr_avail, irq, overflow, underflow;
  logic [DW-1:0] usr_rd_data;
  logic [6:0] fill_level;
  logic [3:0] fill_pending;

  int checks = 0, errors = 0, wr_idx = 0, rd_idx = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  egress_fill_notifier #(.DW(DW), .DEPTH(DEPTH), .THRESH(THRESH)) uut (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
    .src_data(src_data), .src_eop(src_eop), .usr_rd_en(usr_rd_en),
    .usr_avail(usr_avail), .usr_rd_data(usr_rd_data), .irq(irq),
    .irq_clr(irq_clr), .fill_level(fill_level), .fill_pending(fill_pending),
    .overflow(overflow), .underflow(underflow)
  );

  // row: {wr, eop, rd, clr, exp_irq, exp_pend[3:0], exp_level[6:0]}
  localparam logic [15:0] VEC [20] = '{
    16'b1000_0_0001_0000001, 16'b1000_0_0010_0000010,
    16'b1000_0_0011_0000011, 16'b1000_0_0100_0000100,
    16'b1000_0_0101_0000101, 16'b1000_0_0110_0000110,
    16'b1000_0_0111_0000111, 16'b1000_1_0000_0001000,  // R3 block of 8
    16'b0000_1_0000_0001000,                           // R6 sticky
    16'b0001_0_0000_0001000,                           // R6 clear
    16'b1100_1_0000_0001001,                           // R5 early eop
    16'b0010_1_0000_0001000,                           // R11 read only
    16'b1001_0_0001_0001001,                           // R6 clear with plain write
    16'b1010_0_0010_0001001,                           // R10 write+read
    16'b1000_0_0011_0001010, 16'b1000_0_0100_0001011,
    16'b1000_0_0101_0001100, 16'b1000_0_0110_0001101,
    16'b1000_0_0111_0001110,
    16'b1001_1_0000_0001111                            // R7 event beats clear, R4 second block
  };

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic wr, logic eop, logic rd, logic clr, logic [DW-1:0] d);
    src_valid = wr; src_eop = eop; usr_rd_en = rd; irq_clr = clr; src_data = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 level", fill_level, 0);
    chk("R1 pending", fill_pending, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flags", {overflow, underflow, usr_avail, src_ready}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after release", irq, 0);

    // table walk
    for (int i = 0; i < 20; i++) begin
      logic [15:0] v;
      v = VEC[i];
      drive(v[15], v[14], v[13], v[12], BASE + wr_idx);
      if (v[15]) wr_idx++;
      if (v[13]) rd_idx++;
      chk("R3/R5/R6/R7 irq", irq, v[11]);
      chk("R3/R4/R11 pending", fill_pending, v[10:7]);
      chk("R10 level", fill_level, v[6:0]);
    end

    // R2 order: drain everything
    drive(0, 0, 0, 1, '0);
    for (int k = 0; k < 15; k++) begin
      drive(0, 0, 1, 0, '0);
      chk("R2 order", usr_rd_data, BASE + rd_idx);
      rd_idx++;
    end
    drive(0, 0, 0, 0, '0);
    chk("R10 empty avail", {usr_avail, fill_level}, 8'h00);
    chk("R11 drain no irq", irq, 0);

    // R9 empty read
    drive(0, 0, 1, 0, '0);
    chk("R9 data held", usr_rd_data, BASE + 16);
    chk("R9 underflow", underflow, 1);
    chk("R9 level", fill_level, 0);
    chk("R8 no overflow yet", overflow, 0);

    // R8 fill to full, then offer one more
    for (int k = 0; k < DEPTH; k++) begin
      drive(1, 0, 0, 0, BASE + wr_idx);
      wr_idx++;
    end
    chk("R8 full level", fill_level, DEPTH);
    chk("R8 ready low", src_ready, 0);
    chk("R4 irq after blocks", irq, 1);
    chk("R4 pending", fill_pending, 0);
    drive(0, 0, 0, 1, '0);
    chk("R6 cleared", irq, 0);
    drive(1, 1, 0, 0, 32'hDEAD_BEEF);
    drive(0, 0, 0, 0, '0);
    chk("R8 overflow", overflow, 1);
    chk("R8 level held", fill_level, DEPTH);
    chk("R8 dropped eop no irq", irq, 0);
    chk("R8 dropped not counted", fill_pending, 0);

    for (int k = 0; k < DEPTH; k++) begin
      drive(0, 0, 1, 0, '0);
      chk("R2/R8 drain order", usr_rd_data, BASE + rd_idx);
      rd_idx++;
    end
    drive(0, 0, 0, 0, '0);
    chk("R8 nothing extra stored", fill_level, 0);
    chk("R8 overflow sticky", overflow, 1);
    chk("R9 underflow sticky", underflow, 1);
    finish_run();
  end
endmodule